// File: doc/BRIEF.md
# Interrupt Flag and Shared Request Combiner

This block gathers three event sources of a timekeeping subsystem: a time-update event, a periodic-timer event and an alarm-match event. Each source has a sticky flag and an enable bit. Software clears a flag by writing 0 to it. The block drives one active-low interrupt line, suited to an open-drain pad. That line is low whenever any of the three gated requests is active. The logic that generates the events sits elsewhere; this block only receives a one-cycle strobe per event.

The update and timer requests are self-releasing pulses. Their length is counted in cycles of a timebase `tick` derived from a 32.768 kHz reference. The update hold is always the long one, 256 ticks (about 7.8 ms). The timer hold is short (4 ticks, about 122 µs) when the fastest timer source is selected, and long otherwise. The alarm request is a level: it stays active until software clears the alarm flag or drops its enable. Dropping any enable releases that source's request on the next clock edge.

Top module: `evt_irq_hub`

## Requirements
- R1: A strobe on `upd_evt`, `tmr_evt` or `alm_evt` sets flag bit 0, 1 or 2 of `rd_flags` on the next edge. The flag stays 1 until a flag write (`wr_en`=1, `wr_sel`=0) puts 0 in that bit.
- R2: Writing 1 to a flag bit leaves that bit unchanged; it never sets a clear flag.
- R3: A request starts only if the source's enable bit is 1 in the cycle of the event. An enable write (`wr_sel`=1) in the same cycle counts. A disabled event sets its flag and leaves `irq_n` high. Turning the enable on later does not assert `irq_n`.
- R4: `irq_n` is 0 exactly when at least one of the three requests is active. It goes low on the edge that captures an enabled event.
- R5: A timer request lasts 4 ticks when `tmr_src`=0 and 256 ticks for any other `tmr_src` value. It is released on the edge that captures the last of those ticks.
- R6: An update request lasts 256 ticks and is then released without software action.
- R7: Clearing the update or timer flag while its request is active does not release the request.
- R8: Writing 0 to an enable bit releases that source's request on the same edge that stores the write.
- R9: An alarm request stays active as long as its flag and enable stay 1, with no automatic release.
- R10: While `tmr_run` is 0, any timer request is released, and timer events raise only the flag.
- R11: An enabled event that arrives while its own pulse request is active restarts the full hold time.
- R12: After reset, flags and enables read 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_evt | input | 1 | Time-update event strobe |
| tmr_evt | input | 1 | Periodic-timer event strobe |
| alm_evt | input | 1 | Alarm-match event strobe |
| tick | input | 1 | Timebase tick, one cycle wide |
| tmr_src | input | 2 | Timer source select; 0 is the fastest source |
| tmr_run | input | 1 | Periodic timer running |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 flags, 1 enables |
| wr_data | input | 3 | Write data; bit 0 update, bit 1 timer, bit 2 alarm |
| rd_flags | output | 3 | Current flags |
| rd_enables | output | 3 | Current enables |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The bench sweeps every enable pattern against each event source. A design that gated with the wrong bit, or left a disabled event able to pull the line low, would show the wrong `irq_n` level. For every timer source value it checks the line one tick before and exactly at the expected release. An off-by-one counter or a swapped short/long choice would release a tick early or late. It also clears pulse flags while the line is low, which a design that tied pulses to flags would release too early. It retriggers mid-hold, which a design that ignored a second event would release after the first hold. Finally it lets the alarm sit for over 256 ticks, which a design that timed out the alarm would release.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NSRC    = 3;
  localparam int IDX_UPD = 0;
  localparam int IDX_TMR = 1;
  localparam int IDX_ALM = 2;
  localparam int NPULSE  = 2;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import evt_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t evt,
  input  logic     wr_en,
  input  logic     wr_sel,
  input  src_vec_t wr_data,
  output src_vec_t flag_q,
  output src_vec_t en_q,
  output src_vec_t en_nxt,
  output logic     alm_flag_nxt
);
  src_vec_t flag_nxt;
  logic     flag_wr;

  assign flag_wr = wr_en && !wr_sel;
  assign en_nxt  = (wr_en && wr_sel) ? wr_data : en_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    // event wins over a same-cycle clear; writing 1 only keeps the bit
    assign flag_nxt[i] = evt[i] | (flag_q[i] & ~(flag_wr & ~wr_data[i]));

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_nxt[i];
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      flag_q[i] && !(flag_wr && !wr_data[i]) |=> flag_q[i]); // R1
    AST_WRITE_ONE_NOOP: assert property (@(posedge clk) disable iff (rst)
      !flag_q[i] && !evt[i] |=> !flag_q[i]); // R2
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end

  assign alm_flag_nxt = flag_nxt[IDX_ALM];
endmodule

// File: rtl/irq_hold_timer.sv
module irq_hold_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          kill,
  input  logic          tick,
  input  logic [CW-1:0] load_val,
  output logic          active
);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start) begin
      cnt_q <= load_val;
      act_q <= 1'b1;
    end else if (act_q && tick) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) act_q <= 1'b0;
    end
  end

  assign active = act_q;

  AST_KILL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    kill |=> !active); // R8
  AST_START_HOLD: assert property (@(posedge clk) disable iff (rst)
    start && !kill |=> active); // R11
  AST_LAST_TICK: assert property (@(posedge clk) disable iff (rst)
    act_q && tick && cnt_q == CW'(1) && !start && !kill |=> !act_q); // R5
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int SHORT_TICKS = 4,
  parameter int LONG_TICKS  = 256,
  parameter int SRC_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_evt,
  input  logic             tmr_evt,
  input  logic             alm_evt,
  input  logic             tick,
  input  logic [SRC_W-1:0] tmr_src,
  input  logic             tmr_run,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [NSRC-1:0]  wr_data,
  output logic [NSRC-1:0]  rd_flags,
  output logic [NSRC-1:0]  rd_enables,
  output logic             irq_n
);
  localparam int CW = $clog2(LONG_TICKS + 1);

  src_vec_t evt, flag_q, en_q, en_nxt;
  logic     alm_flag_nxt;
  logic     alm_req_q;

  logic [NPULSE-1:0] p_start, p_kill, p_active;
  logic [CW-1:0]     p_load [NPULSE];

  assign evt = {alm_evt, tmr_evt, upd_evt};

  irq_flag_bank i_bank (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .flag_q       (flag_q),
    .en_q         (en_q),
    .en_nxt       (en_nxt),
    .alm_flag_nxt (alm_flag_nxt)
  );

  // pulse sources: index 0 update, index 1 timer
  assign p_start[IDX_UPD] = upd_evt && en_nxt[IDX_UPD];
  assign p_kill[IDX_UPD]  = !en_nxt[IDX_UPD];
  assign p_load[IDX_UPD]  = CW'(LONG_TICKS);

  assign p_start[IDX_TMR] = tmr_evt && en_nxt[IDX_TMR] && tmr_run;
  assign p_kill[IDX_TMR]  = !en_nxt[IDX_TMR] || !tmr_run;
  assign p_load[IDX_TMR]  = (tmr_src == '0) ? CW'(SHORT_TICKS) : CW'(LONG_TICKS);

  for (genvar p = 0; p < NPULSE; p++) begin : g_pulse
    irq_hold_timer #(.CW(CW)) i_hold (
      .clk      (clk),
      .rst      (rst),
      .start    (p_start[p]),
      .kill     (p_kill[p]),
      .tick     (tick),
      .load_val (p_load[p]),
      .active   (p_active[p])
    );
  end

  // alarm: level request held until its flag or enable goes to 0
  always_ff @(posedge clk) begin
    if (rst || !en_nxt[IDX_ALM] || !alm_flag_nxt) alm_req_q <= 1'b0;
    else if (alm_evt)                             alm_req_q <= 1'b1;
  end

  assign irq_n      = !(p_active[IDX_UPD] || p_active[IDX_TMR] || alm_req_q);
  assign rd_flags   = flag_q;
  assign rd_enables = en_q;

  AST_ALARM_NO_AUTO: assert property (@(posedge clk) disable iff (rst)
    alm_req_q && !wr_en |=> alm_req_q); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    rd_enables == '0 |-> irq_n); // R3
  AST_TMR_HALTED: assert property (@(posedge clk) disable iff (rst)
    !tmr_run |=> !p_active[IDX_TMR]); // R10
endmodule

// File: tb/test_evt_irq_hub.sv
module test_evt_irq_hub;
  logic       clk = 0;
  logic       rst = 1;
  logic       upd_evt = 0, tmr_evt = 0, alm_evt = 0, tick = 0;
  logic [1:0] tmr_src = 0;
  logic       tmr_run = 1;
  logic       wr_en = 0, wr_sel = 0;
  logic [2:0] wr_data = 0;
  logic [2:0] rd_flags, rd_enables;
  logic       irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_irq_hub i_evt_irq_hub (
    .clk(clk), .rst(rst), .upd_evt(upd_evt), .tmr_evt(tmr_evt), .alm_evt(alm_evt),
    .tick(tick), .tmr_src(tmr_src), .tmr_run(tmr_run), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_flags(rd_flags), .rd_enables(rd_enables), .irq_n(irq_n)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [2:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic fire(int s);
    upd_evt = (s == 0); tmr_evt = (s == 1); alm_evt = (s == 2);
    @(negedge clk);
    upd_evt = 0; tmr_evt = 0; alm_evt = 0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick = 1; @(negedge clk);
      tick = 0; @(negedge clk);
    end
  endtask

  task automatic clear_all();
    wr(1, 3'b000); wr(0, 3'b000);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 flags", rd_flags, 0);
    chk("R12 enables", rd_enables, 0);
    chk("R12 irq_n", irq_n, 1);

    // R1 R3 R4 R8 sweep of source versus enable pattern
    for (int s = 0; s < 3; s++) begin
      for (int en = 0; en < 8; en++) begin
        clear_all();
        wr(1, 3'(en));
        fire(s);
        chk("R1 flag set", rd_flags, 1 << s);
        chk("R3/R4 gated irq_n", irq_n, ((en >> s) & 1) ? 0 : 1);
        wr(1, 3'b000);
        chk("R8 release on disable", irq_n, 1);
      end
    end

    // R3 enabling after a disabled event does not assert
    clear_all();
    fire(2);
    wr(1, 3'b111);
    chk("R3 late enable", irq_n, 1);
    // R3 same-cycle enable write counts
    clear_all();
    wr_en = 1; wr_sel = 1; wr_data = 3'b001; upd_evt = 1;
    @(negedge clk);
    wr_en = 0; upd_evt = 0;
    chk("R3 same-cycle enable", irq_n, 0);

    // R2 writing ones keeps clear flags clear and set flags set
    clear_all();
    wr(0, 3'b111);
    chk("R2 write one clear", rd_flags, 0);
    fire(0);
    wr(0, 3'b111);
    chk("R2 write one set", rd_flags, 1);
    wr(0, 3'b110);
    chk("R1 clear by zero", rd_flags, 0);

    // R5 timer hold per source
    for (int src = 0; src < 4; src++) begin
      int n;
      n = (src == 0) ? 4 : 256;
      clear_all();
      tmr_src = 2'(src);
      wr(1, 3'b010);
      fire(1);
      ticks(n - 1);
      chk("R5 held before last tick", irq_n, 0);
      ticks(1);
      chk("R5 released at last tick", irq_n, 1);
    end

    // R6 update hold
    clear_all();
    wr(1, 3'b001);
    fire(0);
    ticks(255);
    chk("R6 update held", irq_n, 0);
    ticks(1);
    chk("R6 update released", irq_n, 1);

    // R7 flag clear does not release pulses
    clear_all();
    tmr_src = 0;
    wr(1, 3'b011);
    fire(0);
    fire(1);
    wr(0, 3'b000);
    chk("R7 flags cleared", rd_flags, 0);
    chk("R7 still low", irq_n, 0);
    ticks(4);
    chk("R7 update still low", irq_n, 0);

    // R11 retrigger restarts the hold
    clear_all();
    wr(1, 3'b010);
    fire(1);
    ticks(3);
    fire(1);
    ticks(3);
    chk("R11 held after retrigger", irq_n, 0);
    ticks(1);
    chk("R11 released after full hold", irq_n, 1);

    // R10 stopped timer
    clear_all();
    wr(1, 3'b010);
    fire(1);
    tmr_run = 0;
    @(negedge clk);
    chk("R10 release on stop", irq_n, 1);
    fire(1);
    chk("R10 flag while stopped", rd_flags, 2);
    chk("R10 no request while stopped", irq_n, 1);
    tmr_run = 1;

    // R9 alarm level
    clear_all();
    wr(1, 3'b100);
    fire(2);
    ticks(300);
    chk("R9 alarm held", irq_n, 0);
    wr(0, 3'b011);
    chk("R9 alarm released by flag clear", irq_n, 1);
    fire(2);
    chk("R9 alarm again", irq_n, 0);
    wr(1, 3'b011);
    chk("R9/R8 alarm released by disable", irq_n, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule